// File: doc/BRIEF.md
# Synchronous Power-Down Clock Stopper

This block shuts a group of clock outputs off in response to one active-low power-down request, and does it without a glitch on any pin. The request is qualified against the complement phase of a differential CPU clock. It counts as accepted only when that clock's rising edge sees it low twice in a row, and it is released in the same way. Once the request is accepted, each single-ended output is parked low. One of these outputs is the reference clock. A per-output stop flag crosses into that clock's own domain and takes effect on a falling edge of that clock. As a result an output only stops while its source is already low, and it restarts with a complete first high pulse.

The CPU pair does not simply go low. By default the true pin is held driven high and the complement pin's driver is switched off. A configuration bit, normally written through a register interface but here a plain input, selects three-state on both CPU pins instead. A status output reports that power-down is complete once every output has reached its parked state. All pins are plain control and status signals: the block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pdn_clock_stopper`

## Requirements
- R1: A power-down request (`pd_req_n` = 0) is accepted only if two consecutive rising edges of `cpu_clk_c` both sample it low. A low level seen by only one such edge changes no output.
- R2: The CPU pair enters its parked state at the falling edge of `cpu_clk_c` that follows the accepting rising edge, and not earlier.
- R3: With `cpu_tristate_en` = 0, the parked CPU pair drives `cpu_out_t` = 1 with `cpu_oe_t` = 1, and `cpu_oe_c` = 0 (complement undriven).
- R4: With `cpu_tristate_en` = 1, the parked CPU pair has both `cpu_oe_t` and `cpu_oe_c` at 0.
- R5: Every high pulse on each `gated_clk` bit is exactly one full source high phase, including the last pulse before parking and the first pulse after restart.
- R6: After acceptance at time A, the last rising edge of `gated_clk[i]` falls in (A + P, A + 2P], where P is the period of `src_clk[i]`. This holds for the slow reference clock on bit 0 as well. After that edge the output stays low.
- R7: Release needs `pd_req_n` = 1 on two consecutive `cpu_clk_c` rising edges; a single high sample is ignored. After release at time B, both CPU drivers are enabled at the next `cpu_clk_c` falling edge, and the first rising edge of `gated_clk[i]` falls in (B + 2P, B + 3P].
- R8: `pd_done` is 1 only while the request is accepted and every output is parked. It is 0 before the slowest output has parked, and it returns to 0 at the CPU pair's release.
- R9: While and after `rst_n` is low, with no request accepted, every output follows its source, both CPU drivers are enabled and `pd_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset; clears all stop flags |
| pd_req_n | input | 1 | Active-low power-down request |
| cpu_clk_t | input | 1 | CPU clock, true phase |
| cpu_clk_c | input | 1 | CPU clock, complement phase; sampling reference for the request |
| src_clk | input | N_SE | Free-running single-ended sources; bit 0 is the reference clock |
| cpu_tristate_en | input | 1 | 1: both CPU pins three-state while parked |
| gated_clk | output | N_SE | Gated single-ended clock outputs |
| cpu_out_t | output | 1 | CPU true output value |
| cpu_out_c | output | 1 | CPU complement output value |
| cpu_oe_t | output | 1 | Drive enable of the CPU true pin |
| cpu_oe_c | output | 1 | Drive enable of the CPU complement pin |
| pd_done | output | 1 | All outputs parked |

## Verification
The request edge is swept across four sub-cycle offsets and seven whole CPU-cycle delays, with both settings of the three-state bit. This moves acceptance through every phase relation with three sources of unrelated periods (30, 10 and 14 ns). The sweep separates an off-by-one in the synchroniser depth from a correct design through the exact windows for the last and first pulse. It separates a rising-edge park from a falling-edge park through the pulse-width monitor. One-edge low pulses and one-edge high pulses tell a two-sample qualifier apart from a one-sample one. Checks on the CPU pins half a cycle either side of the accepting edge pin down the park edge.

// File: rtl/pdn_pkg.sv
`timescale 1ns/1ps
package pdn_pkg;
  // drive pattern of the differential CPU pair
  typedef struct packed {
    logic t_val;
    logic c_val;
    logic t_en;
    logic c_en;
  } cpu_pins_t;
endpackage

// File: rtl/pdn_req_qual.sv
`timescale 1ns/1ps
module pdn_req_qual (
  input  logic smp_clk,
  input  logic rst_n,
  input  logic req_n,
  output logic pd_acc
);
  logic prev_n;

  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
      pd_acc <= 1'b0;
    end else begin
      prev_n <= req_n;
      if (!req_n && !prev_n)
        pd_acc <= 1'b1;
      else if (req_n && prev_n)
        pd_acc <= 1'b0;
    end
  end

  assert_accept_two_lows_R1: assert property (@(posedge smp_clk) disable iff (!rst_n)
    $rose(pd_acc) |-> (!prev_n && !$past(prev_n)));
  assert_release_two_highs_R7: assert property (@(posedge smp_clk) disable iff (!rst_n)
    $fell(pd_acc) |-> (prev_n && $past(prev_n)));
endmodule

// File: rtl/pdn_se_gate.sv
`timescale 1ns/1ps
module pdn_se_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic stop_req,
  output logic gated_clk,
  output logic parked
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], stop_req};
  end

  // park changes only while the source is low
  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) parked <= 1'b0;
    else        parked <= sync_q[SYNC_STAGES-1];
  end

  assign gated_clk = src_clk & ~parked;

  assert_park_tracks_sync_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
    parked == sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/pdn_cpu_hold.sv
`timescale 1ns/1ps
module pdn_cpu_hold
  import pdn_pkg::*;
(
  input  logic cpu_t_in,
  input  logic cpu_c_in,
  input  logic rst_n,
  input  logic pd_acc,
  input  logic tri_cfg,
  output logic cpu_t_out,
  output logic cpu_c_out,
  output logic cpu_t_oe,
  output logic cpu_c_oe,
  output logic parked
);
  cpu_pins_t pins;

  // falling edge of complement = true already high, so holding it high is seamless
  always_ff @(negedge cpu_c_in or negedge rst_n) begin
    if (!rst_n) parked <= 1'b0;
    else        parked <= pd_acc;
  end

  always_comb begin
    if (!parked) begin
      pins = '{t_val: cpu_t_in, c_val: cpu_c_in, t_en: 1'b1, c_en: 1'b1};
    end else if (tri_cfg) begin
      pins = '{t_val: 1'b0, c_val: 1'b0, t_en: 1'b0, c_en: 1'b0};
    end else begin
      pins = '{t_val: 1'b1, c_val: 1'b0, t_en: 1'b1, c_en: 1'b0};
    end
  end

  assign cpu_t_out = pins.t_val;
  assign cpu_c_out = pins.c_val;
  assign cpu_t_oe  = pins.t_en;
  assign cpu_c_oe  = pins.c_en;

  assert_cpu_park_edge_R2: assert property (@(posedge cpu_c_in) disable iff (!rst_n)
    parked == pd_acc);
  assert_cpu_default_hold_R3: assert property (@(posedge cpu_c_in) disable iff (!rst_n)
    (!cpu_c_oe && !tri_cfg) |-> (cpu_t_oe && cpu_t_out));
endmodule

// File: rtl/pdn_clock_stopper.sv
`timescale 1ns/1ps
module pdn_clock_stopper #(
  parameter int N_SE        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            rst_n,
  input  logic            pd_req_n,
  input  logic            cpu_clk_t,
  input  logic            cpu_clk_c,
  input  logic [N_SE-1:0] src_clk,
  input  logic            cpu_tristate_en,
  output logic [N_SE-1:0] gated_clk,
  output logic            cpu_out_t,
  output logic            cpu_out_c,
  output logic            cpu_oe_t,
  output logic            cpu_oe_c,
  output logic            pd_done
);
  logic            pd_acc;
  logic            cpu_parked;
  logic [N_SE-1:0] se_parked;
  logic [N_SE-1:0] parked_seen;

  pdn_req_qual u_qual (
    .smp_clk (cpu_clk_c),
    .rst_n   (rst_n),
    .req_n   (pd_req_n),
    .pd_acc  (pd_acc)
  );

  pdn_cpu_hold u_cpu (
    .cpu_t_in  (cpu_clk_t),
    .cpu_c_in  (cpu_clk_c),
    .rst_n     (rst_n),
    .pd_acc    (pd_acc),
    .tri_cfg   (cpu_tristate_en),
    .cpu_t_out (cpu_out_t),
    .cpu_c_out (cpu_out_c),
    .cpu_t_oe  (cpu_oe_t),
    .cpu_c_oe  (cpu_oe_c),
    .parked    (cpu_parked)
  );

  for (genvar g = 0; g < N_SE; g++) begin : g_se
    logic [SYNC_STAGES-1:0] back_q;

    pdn_se_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .src_clk   (src_clk[g]),
      .rst_n     (rst_n),
      .stop_req  (pd_acc),
      .gated_clk (gated_clk[g]),
      .parked    (se_parked[g])
    );

    // bring each park flag back into the CPU-complement domain
    always_ff @(posedge cpu_clk_c or negedge rst_n) begin
      if (!rst_n) back_q <= '0;
      else        back_q <= {back_q[SYNC_STAGES-2:0], se_parked[g]};
    end
    assign parked_seen[g] = back_q[SYNC_STAGES-1];
  end

  assign pd_done = cpu_parked & (&parked_seen);

  assert_done_needs_accept_R8: assert property (@(posedge cpu_clk_c) disable iff (!rst_n)
    pd_done |-> pd_acc);
endmodule

// File: tb/sim_pdn_clock_stopper.sv
`timescale 1ns/1ps
module sim_pdn_clock_stopper;
  localparam int N = 3;
  localparam real PER [N] = '{30.0, 10.0, 14.0};

  logic rst_n, req_n, cpu_c, cfg;
  logic s0, s1, s2;
  logic [N-1:0] src, gclk;
  logic ot, oc, oet, oec, done;
  int n_chk = 0, n_fail = 0, runts = 0;
  real last_rise [N];
  real first_rise [N];
  real rel_t = 0.0;
  real tacc, trel;
  bit finished = 0;

  assign src = {s2, s1, s0};

  pdn_clock_stopper #(.N_SE(N), .SYNC_STAGES(2)) u0 (
    .rst_n(rst_n), .pd_req_n(req_n), .cpu_clk_t(~cpu_c), .cpu_clk_c(cpu_c),
    .src_clk(src), .cpu_tristate_en(cfg), .gated_clk(gclk),
    .cpu_out_t(ot), .cpu_out_c(oc), .cpu_oe_t(oet), .cpu_oe_c(oec), .pd_done(done)
  );

  // 200 MHz CPU complement clock
  initial begin cpu_c = 0; forever #2.5 cpu_c = ~cpu_c; end
  initial begin s0 = 0; #0.3; forever #(PER[0]/2) s0 = ~s0; end
  initial begin s1 = 0; #0.7; forever #(PER[1]/2) s1 = ~s1; end
  initial begin s2 = 0; #1.1; forever #(PER[2]/2) s2 = ~s2; end

  for (genvar g = 0; g < N; g++) begin : g_mon
    initial begin last_rise[g] = 0.0; first_rise[g] = -1.0; end
    always @(posedge gclk[g]) begin
      last_rise[g] = $realtime;
      if (first_rise[g] < rel_t) first_rise[g] = $realtime;
    end
    always @(negedge gclk[g]) begin
      if (rst_n && ($realtime - last_rise[g] > PER[g]/2 + 0.01 ||
                    $realtime - last_rise[g] < PER[g]/2 - 0.01))
        runts++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $realtime);
    end
  endtask

  function automatic longint ps(input real t);
    return longint'(t * 1000.0);
  endfunction

  task automatic check_running(input string tag);
    for (int i = 0; i < N; i++)
      chk(($realtime - last_rise[i]) <= PER[i], tag, ps($realtime - last_rise[i]), ps(PER[i]));
  endtask

  task automatic scenario(input int c, input int j, input int off);
    cfg = c[0];
    // R1: one-edge low pulse is ignored
    @(posedge cpu_c); #(off); req_n = 0;
    @(posedge cpu_c); #1; req_n = 1;
    repeat (4) @(posedge cpu_c); #1;
    chk(oec && oet, "R1 single low ignored (oe)", {oet, oec}, 3);
    check_running("R1 outputs keep toggling");
    // entry
    @(posedge cpu_c); #(j * 5 + off); req_n = 0;
    @(posedge cpu_c); #3.5;
    chk(oec == 1, "R2 not parked after first low edge", oec, 1);
    @(posedge cpu_c); tacc = $realtime; #3.5;
    if (c == 0)
      chk(oet && ot && !oec, "R3 default hold", {oet, ot, oec}, 6);
    else
      chk(!oet && !oec, "R4 three-state hold", {oet, oec}, 0);
    chk(done == 0, "R8 done low before slow output parks", done, 0);
    #(4 * PER[0]);
    for (int i = 0; i < N; i++)
      chk(last_rise[i] > tacc + PER[i] && last_rise[i] <= tacc + 2 * PER[i],
          "R6 last pulse window", ps(last_rise[i] - tacc), ps(2 * PER[i]));
    chk(gclk == 0 && done == 1, "R8 all parked and done", {gclk, done}, 1);
    // R7: one-edge high pulse is ignored
    @(posedge cpu_c); #(off); req_n = 1;
    @(posedge cpu_c); #1; req_n = 0;
    repeat (4) @(posedge cpu_c); #1;
    chk(oec == 0 && done == 1, "R7 single high ignored", {oec, done}, 1);
    for (int i = 0; i < N; i++)
      chk(last_rise[i] <= tacc + 2 * PER[i], "R7 outputs stay parked",
          ps(last_rise[i] - tacc), ps(2 * PER[i]));
    // release
    @(posedge cpu_c); #(off); req_n = 1;
    @(posedge cpu_c); #3.5;
    chk(oec == 0, "R7 not released after first high edge", oec, 0);
    @(posedge cpu_c); trel = $realtime; rel_t = trel; #3.5;
    chk(oet && oec && done == 0, "R7/R8 drivers on, done cleared", {oet, oec, done}, 6);
    #(4 * PER[0]);
    for (int i = 0; i < N; i++)
      chk(first_rise[i] > trel + 2 * PER[i] && first_rise[i] <= trel + 3 * PER[i],
          "R7 first pulse window", ps(first_rise[i] - trel), ps(3 * PER[i]));
    chk(runts == 0, "R5 no runt pulse", runts, 0);
  endtask

  initial begin
    rst_n = 0; req_n = 1; cfg = 0;
    #20;
    chk(oet && oec && done == 0, "R9 reset state", {oet, oec, done}, 6);
    chk(gclk == src, "R9 outputs follow sources in reset", gclk, src);
    rst_n = 1;
    #100;
    check_running("R9 free running after reset");
    chk(gclk == src, "R9 outputs follow sources", gclk, src);
    for (int c = 0; c < 2; c++)
      for (int j = 0; j < 7; j++)
        for (int off = 1; off <= 4; off++)
          scenario(c, j, off);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule